// File: doc/BRIEF.md
# Biphase Push-Field Slave Decoder

This block is the receive side of a device on a single-wire, master-driven serial bus. It takes one sample of the bus line per time slot, qualified by a slot-rate enable. It waits for a frame opening, which is a run of low slots that legal biphase data can never contain. It then checks a synchronisation bit and decodes a field of data bits followed by a field of address bits. Each bit spans two slots, and a bit whose two slots are equal is a coding error.

When the decoded address equals the device's configured address, the block emits a one-cycle strobe together with the received data and address. After the last address bit the master sends a reply-sync bit. When that bit arrives on a frame addressed to this device, the block pulses a go signal so that a separate transmitter can start the reply. Any coding error sets a flag that stays set until reset, and the decoder goes back to searching for the next frame opening.

Top module: `bpd_push_decoder`

## Requirements
- R1: After reset, match_stb, pull_go and frame_err are 0, and rx_data and rx_addr are all zeros.
- R2: While searching, START_SLOTS (3) consecutive enabled samples at level 0 open a frame. A run of only two low samples opens nothing and raises no error. A run of four low samples opens a frame whose sync pair is then wrong, so that frame is rejected with an error.
- R3: The first pair after the opening must be 1 then 0. Any other pair rejects the frame, sets frame_err and gives no strobe.
- R4: A slot pair 1,0 is bit value 0 and a pair 0,1 is bit value 1. DATA_BITS data bits arrive first, then ADDR_BITS address bits, each field least significant bit first. rx_data[0] is therefore the first data bit on the line, and rx_addr[0] is the first address bit.
- R5: A pair with equal levels (0,0 or 1,1) in the data or address field sets frame_err, ends the frame without a strobe and resumes searching. A later clean frame is still decoded.
- R6: match_stb is high for exactly one cycle, and only after an error-free frame whose decoded address equals dev_addr. In that same cycle rx_data and rx_addr show the decoded fields. A frame with any other address gives no strobe and leaves rx_data and rx_addr unchanged.
- R7: After a frame's address field, a pair 0,1 pulses pull_go for one cycle, but only when that frame matched. Any other pair in that position sets frame_err and gives no pull_go.
- R8: A sample taken while slot_en is 0 has no effect on decoding, whatever the line level.
- R9: frame_err, once set, stays set until reset and is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | High in the cycle that carries a slot sample |
| line_in | input | 1 | Bus line level, already synchronised |
| dev_addr | input | ADDR_BITS | Configured address of this device |
| match_stb | output | 1 | One-cycle strobe on an addressed, error-free frame |
| rx_data | output | DATA_BITS | Data field of the last matched frame |
| rx_addr | output | ADDR_BITS | Address field of the last matched frame |
| pull_go | output | 1 | One-cycle pulse: reply sync seen on a matched frame |
| frame_err | output | 1 | Sticky coding or sync error flag |

## Verification
The assertions assume that dev_addr stays constant while frames are in flight, because the strobe check compares the latched address with the live configuration. They also assume that the line is free of metastability and that at most one sample is presented per enabled cycle. The stimulus sets dev_addr once before reset is released. It drives line_in and slot_en only at falling clock edges. Between enabled slots it inserts disabled cycles that carry random or deliberately low line levels, so the ignore rule is exercised without ever breaking these assumptions.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_SYNC = 2'd1,
      ST_BITS = 2'd2,
      ST_PULL = 2'd3
   } bpd_state_e;

   localparam logic SYNC_PUSH_VAL = 1'b0;
   localparam logic SYNC_PULL_VAL = 1'b1;

endpackage

// File: rtl/bpd_start_det.sv
module bpd_start_det #(
   parameter int START_SLOTS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_en,
   input  logic line_in,
   input  logic arm,
   output logic start_hit
);
   localparam int ZW = $clog2(START_SLOTS + 1);
   localparam logic [ZW-1:0] LAST = ZW'(START_SLOTS - 1);

   logic [ZW-1:0] zrun;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zrun <= '0;
      end else if (!arm) begin
         zrun <= '0;
      end else if (slot_en) begin
         if (line_in || (zrun == LAST)) zrun <= '0;
         else                           zrun <= zrun + 1'b1;
      end
   end

   assign start_hit = arm & slot_en & ~line_in & (zrun == LAST);

   // R2: an armed search always begins from an empty low run
   assert_fresh_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm) |-> (zrun == '0));

   // R8: the run counter only moves on enabled samples
   assert_run_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_en && arm && $past(arm)) |=> $stable(zrun));

endmodule

// File: rtl/bpd_pair_dec.sv
module bpd_pair_dec (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_en,
   input  logic line_in,
   input  logic active,
   output logic pair_done,
   output logic pair_bit,
   output logic pair_bad
);
   logic have_first;
   logic first_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_first <= 1'b0;
         first_lvl  <= 1'b0;
      end else if (!active) begin
         have_first <= 1'b0;
      end else if (slot_en) begin
         if (!have_first) begin
            have_first <= 1'b1;
            first_lvl  <= line_in;
         end else begin
            have_first <= 1'b0;
         end
      end
   end

   assign pair_done = active & slot_en & have_first;
   assign pair_bit  = line_in;
   assign pair_bad  = (first_lvl == line_in);

   // R4: two pair completions are always separated by a first-half sample
   assert_pair_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pair_done |=> !pair_done);

endmodule

// File: rtl/bpd_frame_seq.sv
module bpd_frame_seq
   import bpd_pkg::*;
#(
   parameter int DATA_BITS = 5,
   parameter int ADDR_BITS = 3,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_hit,
   input  logic                 pair_done,
   input  logic                 pair_bit,
   input  logic                 pair_bad,
   input  logic [ADDR_BITS-1:0] dev_addr,
   output bpd_state_e           state,
   output logic                 match_stb,
   output logic                 pull_go,
   output logic                 frame_err,
   output logic [DATA_BITS-1:0] rx_data,
   output logic [ADDR_BITS-1:0] rx_addr
);
   localparam int FW = DATA_BITS + ADDR_BITS;
   localparam int CW = $clog2(FW);
   localparam logic [CW-1:0] LAST_BIT = CW'(FW - 1);

   logic [FW-2:0]        shreg;
   logic [FW-2:0]        shreg_nx;
   logic [FW-1:0]        word;
   logic [DATA_BITS-1:0] fld_data;
   logic [ADDR_BITS-1:0] fld_addr;
   logic [CW-1:0]        bcnt;
   logic                 hit;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign word     = {pair_bit, shreg};
         assign shreg_nx = word[FW-1:1];
         assign fld_data = word[DATA_BITS-1:0];
         assign fld_addr = word[FW-1:DATA_BITS];
      end else begin : g_msb
         assign word     = {shreg, pair_bit};
         assign shreg_nx = word[FW-2:0];
         assign fld_data = word[FW-1:ADDR_BITS];
         assign fld_addr = word[ADDR_BITS-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_HUNT;
         shreg     <= '0;
         bcnt      <= '0;
         hit       <= 1'b0;
         match_stb <= 1'b0;
         pull_go   <= 1'b0;
         frame_err <= 1'b0;
         rx_data   <= '0;
         rx_addr   <= '0;
      end else begin
         match_stb <= 1'b0;
         pull_go   <= 1'b0;
         unique case (state)
            ST_HUNT: begin
               if (start_hit) begin
                  state <= ST_SYNC;
                  bcnt  <= '0;
                  hit   <= 1'b0;
               end
            end
            ST_SYNC: begin
               if (pair_done) begin
                  if (pair_bad || (pair_bit != SYNC_PUSH_VAL)) begin
                     frame_err <= 1'b1;
                     state     <= ST_HUNT;
                  end else begin
                     state <= ST_BITS;
                  end
               end
            end
            ST_BITS: begin
               if (pair_done) begin
                  if (pair_bad) begin
                     frame_err <= 1'b1;
                     state     <= ST_HUNT;
                  end else begin
                     shreg <= shreg_nx;
                     if (bcnt == LAST_BIT) begin
                        state <= ST_PULL;
                        if (fld_addr == dev_addr) begin
                           hit       <= 1'b1;
                           match_stb <= 1'b1;
                           rx_data   <= fld_data;
                           rx_addr   <= fld_addr;
                        end
                     end else begin
                        bcnt <= bcnt + 1'b1;
                     end
                  end
               end
            end
            ST_PULL: begin
               if (pair_done) begin
                  state <= ST_HUNT;
                  if (pair_bad || (pair_bit != SYNC_PULL_VAL)) frame_err <= 1'b1;
                  else if (hit)                                pull_go   <= 1'b1;
               end
            end
            default: state <= ST_HUNT;
         endcase
      end
   end

   // R2: a detected opening always leads to the sync check
   assert_open_to_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_hit && state == ST_HUNT) |=> (state == ST_SYNC));

   // R6: strobe lasts one cycle
   assert_stb_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      match_stb |=> !match_stb);

   // R6: strobe only carries this device's address
   assert_stb_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      match_stb |-> (rx_addr == dev_addr));

   // R7: reply go never coincides with the strobe and lasts one cycle
   assert_pull_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pull_go |-> (!match_stb && state == ST_HUNT));

   assert_pull_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pull_go |=> !pull_go);

   // R9: error flag is sticky
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

endmodule

// File: rtl/bpd_push_decoder.sv
module bpd_push_decoder
   import bpd_pkg::*;
#(
   parameter int DATA_BITS   = 5,
   parameter int ADDR_BITS   = 3,
   parameter int START_SLOTS = 3,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 slot_en,
   input  logic                 line_in,
   input  logic [ADDR_BITS-1:0] dev_addr,
   output logic                 match_stb,
   output logic [DATA_BITS-1:0] rx_data,
   output logic [ADDR_BITS-1:0] rx_addr,
   output logic                 pull_go,
   output logic                 frame_err
);
   generate
      if (DATA_BITS < 1 || ADDR_BITS < 1) begin : g_bad_width
         $error("bpd_push_decoder: field widths must be at least 1");
      end
      if (START_SLOTS < 3) begin : g_bad_open
         $error("bpd_push_decoder: opening run must exceed the longest legal low run of 2");
      end
   endgenerate

   bpd_state_e state;
   logic       start_hit;
   logic       pair_done;
   logic       pair_bit;
   logic       pair_bad;
   logic       arm;
   logic       active;

   assign arm    = (state == ST_HUNT);
   assign active = (state != ST_HUNT);

   bpd_start_det #(
      .START_SLOTS (START_SLOTS)
   ) u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_en   (slot_en),
      .line_in   (line_in),
      .arm       (arm),
      .start_hit (start_hit)
   );

   bpd_pair_dec u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_en   (slot_en),
      .line_in   (line_in),
      .active    (active),
      .pair_done (pair_done),
      .pair_bit  (pair_bit),
      .pair_bad  (pair_bad)
   );

   bpd_frame_seq #(
      .DATA_BITS (DATA_BITS),
      .ADDR_BITS (ADDR_BITS),
      .LSB_FIRST (LSB_FIRST)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_hit (start_hit),
      .pair_done (pair_done),
      .pair_bit  (pair_bit),
      .pair_bad  (pair_bad),
      .dev_addr  (dev_addr),
      .state     (state),
      .match_stb (match_stb),
      .pull_go   (pull_go),
      .frame_err (frame_err),
      .rx_data   (rx_data),
      .rx_addr   (rx_addr)
   );

   // R8: a disabled cycle produces no strobe or go pulse
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_en |=> (!match_stb && !pull_go));

   // R8: a disabled cycle leaves the decode state untouched
   assert_idle_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_en |=> $stable(state));

endmodule

// File: tb/bpd_push_decoder_bench.sv
module bpd_push_decoder_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] DEV = 3'd5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slot_en = 1'b0;
   logic       line_in = 1'b1;
   logic [2:0] dev_addr = DEV;
   logic       match_stb;
   logic [4:0] rx_data;
   logic [2:0] rx_addr;
   logic       pull_go;
   logic       frame_err;

   int n_chk = 0;
   int n_fail = 0;
   int n_match = 0;
   int n_pull = 0;
   int gap_zero = 0;
   logic [4:0] seen_data = '0;
   logic [2:0] seen_addr = '0;
   logic       exp_err = 1'b0;
   logic [4:0] exp_data = '0;
   logic [2:0] exp_addr = '0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bpd_push_decoder u_bpd_push_decoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_en   (slot_en),
      .line_in   (line_in),
      .dev_addr  (dev_addr),
      .match_stb (match_stb),
      .rx_data   (rx_data),
      .rx_addr   (rx_addr),
      .pull_go   (pull_go),
      .frame_err (frame_err)
   );

   always @(negedge clk) begin
      if (match_stb) begin
         n_match   <= n_match + 1;
         seen_data <= rx_data;
         seen_addr <= rx_addr;
      end
      if (pull_go) n_pull <= n_pull + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic slot(input logic lvl);
      @(negedge clk);
      slot_en = 1'b1;
      line_in = lvl;
      @(negedge clk);
      slot_en = 1'b0;
      line_in = (gap_zero != 0) ? 1'b0 : 1'($urandom);
      repeat ($urandom % 3) @(negedge clk);
   endtask

   task automatic pair(input logic b);
      slot(~b);
      slot(b);
   endtask

   // bad_at: -1 none, 0 the sync pair, 1..8 data/address bit index + 1
   task automatic send_frame(input int nstart, input logic [4:0] d, input logic [2:0] a,
                             input int bad_at, input logic sync_v, input logic pull_v);
      logic b;
      for (int i = 0; i < nstart; i++) slot(1'b0);
      if (bad_at == 0) begin slot(1'b1); slot(1'b1); end
      else pair(sync_v);
      for (int i = 0; i < 8; i++) begin
         b = (i < 5) ? d[i] : a[i-5];
         if (bad_at == i + 1) begin slot(1'b1); slot(1'b1); end
         else pair(b);
      end
      pair(pull_v);
      slot(1'b1);
      slot(1'b1);
   endtask

   function automatic logic frame_opens(input int nstart);
      return nstart >= 3;
   endfunction

   function automatic logic frame_clean(input int nstart, input int bad_at, input logic sync_v);
      return (nstart == 3) && (bad_at < 0) && (sync_v == 1'b0);
   endfunction

   task automatic run_frame(input string req, input int nstart, input logic [4:0] d,
                            input logic [2:0] a, input int bad_at, input logic sync_v,
                            input logic pull_v);
      int m0, p0;
      logic clean, em, ep;
      m0 = n_match;
      p0 = n_pull;
      send_frame(nstart, d, a, bad_at, sync_v, pull_v);
      clean = frame_clean(nstart, bad_at, sync_v);
      em = clean && (a == DEV);
      ep = em && pull_v;
      if (frame_opens(nstart) && (!clean || !pull_v)) exp_err = 1'b1;
      if (em) begin exp_data = d; exp_addr = a; end
      check({req, " strobe count"}, n_match - m0, int'(em));
      check({req, " pull_go count"}, n_pull - p0, int'(ep));
      check({req, " frame_err"}, int'(frame_err), int'(exp_err));
      check({req, " rx_data"}, int'(rx_data), int'(exp_data));
      check({req, " rx_addr"}, int'(rx_addr), int'(exp_addr));
      if (em) check({req, " strobe data"}, int'(seen_data), int'(d));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      check("R1 match_stb", int'(match_stb), 0);
      check("R1 pull_go", int'(pull_go), 0);
      check("R1 frame_err", int'(frame_err), 0);
      check("R1 rx_data", int'(rx_data), 0);
      check("R1 rx_addr", int'(rx_addr), 0);

      // R2 two low slots open nothing
      run_frame("R2 short opening", 2, 5'b10101, DEV, -1, 1'b0, 1'b1);
      // R4 bit order and pair decode, R6 match, R7 pull go
      run_frame("R4 R6 R7 clean frame", 3, 5'b10110, DEV, -1, 1'b0, 1'b1);
      run_frame("R4 lsb data", 3, 5'b00001, DEV, -1, 1'b0, 1'b1);
      // R6 other address: no strobe, fields kept; R7 no pull_go
      run_frame("R6 R7 foreign address", 3, 5'b11111, 3'd2, -1, 1'b0, 1'b1);
      // R8 line held low during disabled cycles
      gap_zero = 1;
      run_frame("R8 low gaps", 3, 5'b01001, DEV, -1, 1'b0, 1'b1);
      gap_zero = 0;
      // R7 wrong reply sync pair
      run_frame("R7 bad reply sync", 3, 5'b00111, DEV, -1, 1'b0, 1'b0);
      // R9 sticky, cleared by reset
      @(negedge clk);
      check("R9 sticky flag", int'(frame_err), 1);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_err = 1'b0; exp_data = '0; exp_addr = '0;
      @(negedge clk);
      check("R9 cleared by reset", int'(frame_err), 0);
      // R3 wrong sync bit value and illegal sync pair
      run_frame("R3 sync decodes 1", 3, 5'b11000, DEV, -1, 1'b1, 1'b1);
      run_frame("R3 sync pair illegal", 3, 5'b11000, DEV, 0, 1'b0, 1'b1);
      // R2 four-slot opening misaligns the sync pair
      run_frame("R2 long opening", 4, 5'b01100, DEV, -1, 1'b0, 1'b1);
      // R5 illegal pair in data and in address, then recovery
      run_frame("R5 bad data pair", 3, 5'b10011, DEV, 2, 1'b0, 1'b1);
      run_frame("R5 bad addr pair", 3, 5'b10011, DEV, 8, 1'b0, 1'b1);
      run_frame("R5 recovery", 3, 5'b01110, DEV, -1, 1'b0, 1'b1);

      for (int k = 0; k < 40; k++) begin
         logic [4:0] d;
         logic [2:0] a;
         int bad;
         d   = 5'($urandom);
         a   = ($urandom % 2 != 0) ? DEV : 3'($urandom);
         bad = ($urandom % 8 == 0) ? int'($urandom % 9) : -1;
         run_frame("R4 R5 R6 R7 random", 3, d, a, bad,
                   ($urandom % 10 == 0) ? 1'b1 : 1'b0,
                   ($urandom % 6 == 0) ? 1'b0 : 1'b1);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule